// File: doc/BRIEF.md
# UART Bus Register File

This block is the bus-facing register set of a classic eight-bit serial port controller. A host reaches eight byte-wide offsets through a three-bit address, a write strobe and a read strobe. It can queue a byte for transmission, collect a received byte, program the frame format and the baud divisor, drive the two modem handshake outputs and observe the four modem handshake inputs. Read data is combinational from the current register state. A read strobe has side effects only at the clock edge that ends the access.

The serial shift engines and the baud rate generator sit outside this block. The transmit side gets a held byte and a one-cycle load pulse, and reports back through a done pulse when the holding register may be refilled. The receive side delivers a byte with a valid pulse and reports line breaks with a separate pulse. The divisor and frame configuration are plain outputs. A single interrupt line combines three pending causes, each gated by its own enable bit.

Top module: `uart_regs`

## Requirements
- R1: After reset, the divisor output equals the DIV_RESET parameter and the line control, interrupt enable and modem control registers read 0. Line status reads 0x20 (transmit empty only), and dtr_o, rts_o and irq_o are low.
- R2: When line-control bit 7 is set, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte. Writes made there neither load the transmitter nor change the interrupt enables.
- R3: With line-control bit 7 clear, a write to offset 0 places the byte on tx_data_o and raises tx_load_o for exactly the following cycle. It clears line-status bit 5 (transmit empty), and a tx_done_i pulse sets bit 5 again.
- R4: An rx_valid_i pulse stores rx_data_i and sets line-status bit 0 (receive ready). With line-control bit 7 clear, a read strobe at offset 0 returns the stored byte and clears bit 0.
- R5: A byte arriving while receive ready is set, without a buffer read in the same cycle, sets line-status bit 1 (overrun). The buffer then holds the newest byte.
- R6: An rx_break_i pulse sets line-status bit 4. A read strobe at offset 5 clears bits 1 and 4 unless a new event arrives in the same cycle.
- R7: Offset 1 (bit 7 of line control clear) holds three enables: bit 0 receive ready, bit 1 transmit empty, bit 2 modem change. Bits 7:3 read 0.
- R8: Offset 2 reads bit 0 = receive ready AND enable 0, bit 1 = transmit empty AND enable 1, bit 2 = modem change AND enable 2, and 0 in the other bits. Writes to offset 2 have no effect.
- R9: irq_o is high exactly when any offset-2 bit is set, and stays high until the causing condition or its enable is cleared.
- R10: Offset 4 holds bit 0 driving dtr_o and bit 1 driving rts_o. Its other bits read 0.
- R11: Offset 6 reports cts_i, dsr_i, ri_i and dcd_i in bits 4, 5, 6 and 7, one cycle after they are sampled. Bit 0 sets when any of them changes and is cleared by a read strobe at offset 6.
- R12: Offset 3 is a full eight-bit read/write register and frame_cfg_o carries its bits 6:0. Offset 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects only) |
| rdata_o | output | DATA_W | Read data for addr_i |
| tx_data_o | output | DATA_W | Byte held for the transmit shifter |
| tx_load_o | output | 1 | One-cycle pulse after a transmit write |
| tx_done_i | input | 1 | Transmit shifter took the byte |
| rx_data_i | input | DATA_W | Received byte |
| rx_valid_i | input | 1 | Received byte valid pulse |
| rx_break_i | input | 1 | Line break detected pulse |
| divisor_o | output | 2*DATA_W | Baud divisor |
| frame_cfg_o | output | DATA_W-1 | Frame format bits of line control |
| dtr_o | output | 1 | Data terminal ready output |
| rts_o | output | 1 | Request to send output |
| cts_i | input | 1 | Clear to send input |
| dsr_i | input | 1 | Data set ready input |
| ri_i | input | 1 | Ring indicator input |
| dcd_i | input | 1 | Carrier detect input |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default DATA_W of 8 and DIV_RESET of 1. This gives the register layout the host sees and lets the reset divisor be read back through the banked offsets. Because divisor access is a single random bit in line control, random writes often land in both bank states. The same stream mixes byte arrivals, break pulses, transmit completions and modem pin changes, so overrun collisions, clears on status reads and interrupt masking recur many times against the bench model.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_IRQ  = 3;
  localparam int unsigned N_MDM  = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_PEND  = 3'd2,
    OFS_LINE  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_NONE  = 3'd7
  } reg_ofs_e;

  // line status bit positions
  localparam int unsigned LS_RDY  = 0;
  localparam int unsigned LS_OVR  = 1;
  localparam int unsigned LS_BRK  = 4;
  localparam int unsigned LS_TEMT = 5;

  // interrupt cause positions
  localparam int unsigned IRQ_RX  = 0;
  localparam int unsigned IRQ_TX  = 1;
  localparam int unsigned IRQ_MDM = 2;

  localparam int unsigned DIV_ACCESS_BIT = 7;
  localparam int unsigned MS_PIN_LSB     = 4;
endpackage

// File: rtl/uart_rx_path.sv
module uart_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_break_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              break_o
);
  logic ovr_set;
  assign ovr_set = rx_valid_i && ready_o && !rd_buf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o     <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      break_o   <= 1'b0;
    end else begin
      if (rx_valid_i) buf_o <= rx_data_i;
      ready_o   <= rx_valid_i || (ready_o && !rd_buf_i);
      overrun_o <= ovr_set || (overrun_o && !rd_stat_i);
      break_o   <= rx_break_i || (break_o && !rd_stat_i);
    end
  end

  a_r4_arrival_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> ready_o);
  a_r4_read_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_buf_i && !rx_valid_i) |=> !ready_o);
  a_r5_collision_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && ready_o && !rd_buf_i) |=> overrun_o);
  a_r6_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !rx_break_i && !rx_valid_i) |=> (!break_o && !overrun_o));
endmodule

// File: rtl/uart_modem_if.sv
module uart_modem_if
  import uart_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic [1:0]       wdata_i,
  input  logic             rd_stat_i,
  input  logic [N_MDM-1:0] pins_i,
  output logic [1:0]       ctrl_o,
  output logic [N_MDM-1:0] pins_o,
  output logic             change_o
);
  logic [N_MDM-1:0] delta;

  for (genvar k = 0; k < N_MDM; k++) begin : g_delta
    assign delta[k] = pins_i[k] ^ pins_o[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      pins_o   <= '0;
      change_o <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_o <= wdata_i;
      pins_o   <= pins_i;
      change_o <= (|delta) || (change_o && !rd_stat_i);
    end
  end

  a_r11_change_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i != pins_o) |=> change_o);
  a_r11_read_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && pins_i == pins_o) |=> !change_o);
  a_r10_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> ctrl_o == $past(wdata_i));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] pending_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enable_o <= '0;
    else if (wr_en_i) enable_o <= wdata_i;
  end

  assign pending_o = cond_i & enable_o;
  assign irq_o     = |pending_o;

  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|enable_o));
  a_r9_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|cond_i));
  a_r7_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> enable_o == $past(wdata_i));
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W-1:0]   tx_data_o,
  output logic                tx_load_o,
  input  logic                tx_done_i,
  input  logic [DATA_W-1:0]   rx_data_i,
  input  logic                rx_valid_i,
  input  logic                rx_break_i,
  output logic [2*DATA_W-1:0] divisor_o,
  output logic [DATA_W-2:0]   frame_cfg_o,
  output logic                dtr_o,
  output logic                rts_o,
  input  logic                cts_i,
  input  logic                dsr_i,
  input  logic                ri_i,
  input  logic                dcd_i,
  output logic                irq_o
);
  localparam int unsigned DIV_W = 2 * DATA_W;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  reg_ofs_e ofs;
  logic dab;
  logic [DATA_W-1:0] lcr_q, dll_q, dlm_q;
  logic temt_q;
  logic wr_thr, wr_dll, wr_dlm, wr_ier, wr_lcr, wr_mcr;
  logic rd_rbr, rd_lsr, rd_msr;

  logic [DATA_W-1:0] rx_buf;
  logic rx_rdy, rx_ovr, rx_brk;
  logic [1:0] mcr;
  logic [N_MDM-1:0] mdm_pins;
  logic mdm_chg;
  logic [N_IRQ-1:0] ien, pend, cause;
  logic [DATA_W-1:0] lsr, msr;

  assign ofs = reg_ofs_e'(addr_i);
  assign dab = lcr_q[DIV_ACCESS_BIT];

  assign wr_thr = wr_i && ofs == OFS_DATA && !dab;
  assign wr_dll = wr_i && ofs == OFS_DATA &&  dab;
  assign wr_ier = wr_i && ofs == OFS_IEN  && !dab;
  assign wr_dlm = wr_i && ofs == OFS_IEN  &&  dab;
  assign wr_lcr = wr_i && ofs == OFS_LINE;
  assign wr_mcr = wr_i && ofs == OFS_MCTL;
  assign rd_rbr = rd_i && ofs == OFS_DATA && !dab;
  assign rd_lsr = rd_i && ofs == OFS_LSTAT;
  assign rd_msr = rd_i && ofs == OFS_MSTAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q     <= '0;
      dll_q     <= DIV_INIT[DATA_W-1:0];
      dlm_q     <= DIV_INIT[DIV_W-1:DATA_W];
      tx_data_o <= '0;
      tx_load_o <= 1'b0;
      temt_q    <= 1'b1;
    end else begin
      if (wr_lcr) lcr_q <= wdata_i;
      if (wr_dll) dll_q <= wdata_i;
      if (wr_dlm) dlm_q <= wdata_i;
      if (wr_thr) tx_data_o <= wdata_i;
      tx_load_o <= wr_thr;
      if (wr_thr)         temt_q <= 1'b0;
      else if (tx_done_i) temt_q <= 1'b1;
    end
  end

  uart_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_break_i (rx_break_i),
    .rd_buf_i   (rd_rbr),
    .rd_stat_i  (rd_lsr),
    .buf_o      (rx_buf),
    .ready_o    (rx_rdy),
    .overrun_o  (rx_ovr),
    .break_o    (rx_brk)
  );

  uart_modem_if u_mdm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_mcr),
    .wdata_i   (wdata_i[1:0]),
    .rd_stat_i (rd_msr),
    .pins_i    ({dcd_i, ri_i, dsr_i, cts_i}),
    .ctrl_o    (mcr),
    .pins_o    (mdm_pins),
    .change_o  (mdm_chg)
  );

  always_comb begin
    cause = '0;
    cause[IRQ_RX]  = rx_rdy;
    cause[IRQ_TX]  = temt_q;
    cause[IRQ_MDM] = mdm_chg;
  end

  uart_irq_ctrl #(.N(N_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ier),
    .wdata_i   (wdata_i[N_IRQ-1:0]),
    .cond_i    (cause),
    .enable_o  (ien),
    .pending_o (pend),
    .irq_o     (irq_o)
  );

  always_comb begin
    lsr = '0;
    lsr[LS_RDY]  = rx_rdy;
    lsr[LS_OVR]  = rx_ovr;
    lsr[LS_BRK]  = rx_brk;
    lsr[LS_TEMT] = temt_q;
    msr = '0;
    msr[0] = mdm_chg;
    msr[MS_PIN_LSB +: N_MDM] = mdm_pins;
  end

  always_comb begin
    rdata_o = '0;
    unique case (ofs)
      OFS_DATA:  rdata_o = dab ? dll_q : rx_buf;
      OFS_IEN:   rdata_o = dab ? dlm_q : DATA_W'(ien);
      OFS_PEND:  rdata_o = DATA_W'(pend);
      OFS_LINE:  rdata_o = lcr_q;
      OFS_MCTL:  rdata_o = DATA_W'(mcr);
      OFS_LSTAT: rdata_o = lsr;
      OFS_MSTAT: rdata_o = msr;
      default:   rdata_o = '0;
    endcase
  end

  assign divisor_o   = {dlm_q, dll_q};
  assign frame_cfg_o = lcr_q[DATA_W-2:0];
  assign dtr_o       = mcr[0];
  assign rts_o       = mcr[1];

  a_r3_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_thr |=> (!temt_q && tx_load_o));
  a_r3_done_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !wr_thr) |=> temt_q);
  a_r2_banked_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs == OFS_DATA && dab) |=> !tx_load_o);
  a_r2_banked_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ofs == OFS_IEN && dab) |=> (divisor_o[DIV_W-1:DATA_W] == $past(wdata_i) && $stable(ien)));
endmodule

// File: tb/test_uart_regs.sv
module test_uart_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata, tx_data, rx_data = '0;
  logic tx_load, tx_done = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [15:0] divisor;
  logic [6:0] frame_cfg;
  logic dtr, rts, irq;
  logic [3:0] pins = '0;  // {dcd, ri, dsr, cts}

  int n_chk = 0, n_fail = 0;

  // model
  logic [7:0] m_lcr = 0, m_dll = 1, m_dlm = 0, m_buf = 0, m_thr = 0;
  logic [2:0] m_ier = 0;
  logic [1:0] m_mcr = 0;
  logic [3:0] m_pins = 0;
  logic m_rdy = 0, m_ovr = 0, m_brk = 0, m_temt = 1, m_chg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regs i_uart_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .tx_data_o(tx_data), .tx_load_o(tx_load), .tx_done_i(tx_done),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_break_i(rx_break),
    .divisor_o(divisor), .frame_cfg_o(frame_cfg), .dtr_o(dtr), .rts_o(rts),
    .cts_i(pins[0]), .dsr_i(pins[1]), .ri_i(pins[2]), .dcd_i(pins[3]), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_pend();
    return {5'b0, m_chg & m_ier[2], m_temt & m_ier[1], m_rdy & m_ier[0]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic dab = m_lcr[7];
    case (a)
      3'd0: return dab ? m_dll : m_buf;
      3'd1: return dab ? m_dlm : {5'b0, m_ier};
      3'd2: return m_pend();
      3'd3: return m_lcr;
      3'd4: return {6'b0, m_mcr};
      3'd5: return {2'b0, m_temt, m_brk, 2'b0, m_ovr, m_rdy};
      3'd6: return {m_pins, 3'b0, m_chg};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? "R2" : "R4";
      3'd1: return m_lcr[7] ? "R2" : "R7";
      3'd2: return "R8";
      3'd4: return "R10";
      3'd5: return "R6";
      3'd6: return "R11";
      default: return "R12";
    endcase
  endfunction

  // side-effect-free sweep of all offsets and outputs; called at negedge
  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk(req_of(3'(a)), rdata, exp_read(3'(a)));
    end
    chk("R9", irq, |m_pend());
    chk("R2", divisor, {m_dlm, m_dll});
    chk("R10", {rts, dtr}, m_mcr);
    chk("R12", frame_cfg, m_lcr[6:0]);
  endtask

  task automatic op_write(input logic [2:0] a, input logic [7:0] d);
    logic thr = (a == 0) && !m_lcr[7];
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    case (a)
      3'd0: if (m_lcr[7]) m_dll = d; else begin m_thr = d; m_temt = 0; end
      3'd1: if (m_lcr[7]) m_dlm = d; else m_ier = d[2:0];
      3'd3: m_lcr = d;
      3'd4: m_mcr = d[1:0];
      default: ;
    endcase
    chk("R3", tx_load, thr);
    if (thr) chk("R3", tx_data, d);
  endtask

  task automatic op_read(input logic [2:0] a);
    logic [7:0] e = exp_read(a);
    logic [7:0] got;
    @(negedge clk); addr = a; rd = 1'b1;
    #1 got = rdata;
    @(negedge clk); rd = 1'b0;
    chk(req_of(a), got, e);
    if (a == 0 && !m_lcr[7]) m_rdy = 0;
    if (a == 5) begin m_ovr = 0; m_brk = 0; end
    if (a == 6) m_chg = 0;
  endtask

  task automatic op_rx(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    if (m_rdy) m_ovr = 1;
    m_buf = d; m_rdy = 1;
  endtask

  task automatic op_txdone();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    m_temt = 1;
  endtask

  task automatic op_break();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    m_brk = 1;
  endtask

  task automatic op_pins(input logic [3:0] p);
    @(negedge clk); pins = p;
    @(negedge clk);
    if (p != m_pins) m_chg = 1;
    m_pins = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", divisor, 16'd1);
    chk("R1", irq, 1'b0);
    chk("R1", {dtr, rts}, 2'b00);
    addr = 3'd5; #1 chk("R1", rdata, 8'h20);
    addr = 3'd3; #1 chk("R1", rdata, 8'h00);
    check_all();

    // R3 transmit write then done
    op_write(3'd0, 8'hA5);
    @(negedge clk); chk("R3", tx_load, 1'b0);
    addr = 3'd5; #1 chk("R3", rdata[5], 1'b0);
    op_txdone();
    addr = 3'd5; #1 chk("R3", rdata[5], 1'b1);

    // R4/R5 receive, overrun, read clear
    op_rx(8'h11);
    addr = 3'd5; #1 chk("R4", rdata[0], 1'b1);
    op_rx(8'h22);
    addr = 3'd5; #1 chk("R5", rdata[1], 1'b1);
    op_read(3'd0);
    addr = 3'd5; #1 chk("R4", rdata[0], 1'b0);
    // R6 break then status read clears overrun and break
    op_break();
    addr = 3'd5; #1 chk("R6", rdata[4], 1'b1);
    op_read(3'd5);
    addr = 3'd5; #1 chk("R6", rdata & 8'h12, 8'h00);

    // R9 interrupt held until cause cleared
    op_write(3'd1, 8'hFF);
    addr = 3'd1; #1 chk("R7", rdata, 8'h07);
    op_write(3'd2, 8'hFF);  // R8: ignored write
    op_rx(8'h33);
    repeat (3) @(negedge clk);
    chk("R9", irq, 1'b1);
    op_read(3'd0);
    op_write(3'd0, 8'h44);  // clears transmit empty
    chk("R9", irq, 1'b0);
    op_txdone();

    // R11 modem pins
    op_pins(4'b1010);
    addr = 3'd6; #1 chk("R11", rdata, 8'hA1);
    chk("R9", irq, 1'b1);
    op_read(3'd6);
    addr = 3'd6; #1 chk("R11", rdata, 8'hA0);

    // R2 divisor banking
    op_write(3'd3, 8'h83);
    op_write(3'd0, 8'h5C);
    op_write(3'd1, 8'h12);
    chk("R2", divisor, 16'h125C);
    op_write(3'd3, 8'h03);
    addr = 3'd1; #1 chk("R2", rdata, 8'h07);
    op_write(3'd7, 8'hEE);  // R12: ignored
    op_write(3'd4, 8'hFF);  // R10
    check_all();

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: op_write(3'($urandom_range(0, 7)), 8'($urandom));
        3, 4:    op_read(3'($urandom_range(0, 7)));
        5, 6:    op_rx(8'($urandom));
        7:       op_txdone();
        8:       op_break();
        default: op_pins(4'($urandom));
      endcase
      check_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule